// File: doc/BRIEF.md
# Doorbell Interrupt Unit for Inter-Processor and Message-Signalled Interrupts

This block keeps, for each CPU of a cluster, a 32-bit doorbell pending register and a 32-bit enable register. A shared trigger port, written by CPUs to interrupt one another and by PCIe endpoints as the landing spot of their message-signalled interrupts, sets doorbell bits. Each trigger write names one doorbell bit and a bitmap of the CPUs that receive it.

Every CPU gets two level outputs that feed the interrupt routing controller. One covers the inter-processor group, doorbell bits 0 to 7. The other covers the message-signalled group, bits 16 to 31. Bits 8 to 15 can be set and read back, but they never raise either output.

Software reaches the per-CPU registers through a small write/read port. A CPU index picks the bank, and a register offset picks pending (0x8) or enable (0xC). Pending bits are acknowledged by writing zeros.

Top module: `dbu_doorbell_unit`

## Requirements
- R1: After reset, every pending and enable register reads zero, and both level outputs of every CPU are low.
- R2: A trigger write with value d sets pending bit d[4:0] of every CPU c whose bit d[8+c] is 1. CPUs whose map bit is 0 are not changed, and no other bit is changed.
- R3: A trigger value of 0xF00 | (16+n), for n from 0 to 15, sets pending bit 16+n of all four CPUs.
- R4: A register write at offset 0x8 clears each pending bit of the selected CPU whose data bit is 0. Bits written as 1 keep their value. Other CPUs are unaffected.
- R5: A register write at offset 0xC loads the selected CPU's enable register, where 1 means enabled. A read at offset 0xC returns the loaded value.
- R6: `ipi_irq[c]` is high exactly when some bit in 0..7 is both pending and enabled for CPU c.
- R7: `msi_irq[c]` is high exactly when some bit in 16..31 is both pending and enabled for CPU c.
- R8: Pending bits 8..15 can be set and read back, but they never raise either output, even when enabled.
- R9: When a trigger and a pending-clear write hit the same bit of the same CPU in the same cycle, the bit ends up set.
- R10: A read at offset 0x8 returns the selected CPU's pending register. A read at any offset other than 0x8 or 0xC returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_valid | input | 1 | Trigger write strobe |
| trig_data | input | 32 | Trigger value: bits 4:0 hold the doorbell number, bits 8+c select CPU c |
| reg_we | input | 1 | Per-CPU register write strobe |
| reg_addr | input | 4 | Register offset (0x8 pending, 0xC enable) |
| reg_cpu | input | 2 | CPU bank index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the address, CPU index and stored state |
| ipi_irq | output | 4 | Per-CPU inter-processor group level |
| msi_irq | output | 4 | Per-CPU message-signalled group level |

## Verification
A trigger from the shared port and a pending-clear write from the register port can land in the same cycle. They may hit the same CPU and the same bit, or different CPUs. The bench provokes this by driving both strobes in one cycle, first while the targeted bit is already pending and then while it is idle. It then reads every bank back: the triggered bit must be set, the other bits of the written bank must follow the clear mask, and the other banks must be unchanged. Around this case, the bench sweeps every doorbell number against every CPU map and checks each result against a reference model kept in the bench.

// File: rtl/dbu_pkg.sv
package dbu_pkg;

    localparam int DB_W      = 32;
    localparam int NUM_W     = 5;
    localparam int MAP_LSB   = 8;
    localparam int IPI_LO    = 0;
    localparam int IPI_HI    = 7;
    localparam int MSI_LO    = 16;
    localparam int MSI_HI    = 31;

    localparam logic [3:0] OFS_PEND = 4'h8;
    localparam logic [3:0] OFS_ENAB = 4'hC;

    typedef struct packed {
        logic [DB_W-1:0] pend;
        logic [DB_W-1:0] enab;
    } bank_t;

    function automatic logic [DB_W-1:0] grp_mask(input int lo, input int hi);
        logic [DB_W-1:0] m;
        m = '0;
        for (int i = 0; i < DB_W; i++) begin
            if (i >= lo && i <= hi) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/dbu_trig_decode.sv
module dbu_trig_decode
    import dbu_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           trig_valid,
    input  logic [DB_W-1:0]                trig_data,
    output logic [NUM_CPU-1:0][DB_W-1:0]   set_o
);

    logic [DB_W-1:0]    bit_sel;
    logic [NUM_CPU-1:0] cpu_map;

    always_comb begin
        bit_sel = '0;
        bit_sel[trig_data[NUM_W-1:0]] = 1'b1;
        cpu_map = trig_data[MAP_LSB +: NUM_CPU];
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        always_comb begin
            set_o[c] = (trig_valid && cpu_map[c]) ? bit_sel : '0;
        end

        assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(set_o[c]));
    end

endmodule

// File: rtl/dbu_cpu_bank.sv
module dbu_cpu_bank
    import dbu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DB_W-1:0]  set_i,
    input  logic             pend_we_i,
    input  logic             enab_we_i,
    input  logic [DB_W-1:0]  wdata_i,
    output logic [DB_W-1:0]  pend_o,
    output logic [DB_W-1:0]  enab_o
);

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pend_we_i) st_d.pend = st_q.pend & wdata_i;
        st_d.pend = st_d.pend | set_i;
        if (enab_we_i) st_d.enab = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign enab_o = st_q.enab;

    assert_trig_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_we_i && set_i == '0) |=> $stable(pend_o));

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pend_we_i |=> ((pend_o & ~($past(wdata_i) | $past(set_i))) == '0));

    assert_trig_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_we_i && ((set_i & ~wdata_i) != '0))
            |=> ((pend_o & $past(set_i)) == $past(set_i)));

    assert_enab_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        enab_we_i |=> (enab_o == $past(wdata_i)));

endmodule

// File: rtl/dbu_group_sum.sv
module dbu_group_sum
    import dbu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DB_W-1:0]  pend_i,
    input  logic [DB_W-1:0]  enab_i,
    output logic             ipi_o,
    output logic             msi_o
);

    localparam logic [DB_W-1:0] IPI_M = grp_mask(IPI_LO, IPI_HI);
    localparam logic [DB_W-1:0] MSI_M = grp_mask(MSI_LO, MSI_HI);
    localparam logic [DB_W-1:0] RSV_M = ~(IPI_M | MSI_M);

    logic [DB_W-1:0] live;

    always_comb begin
        live  = pend_i & enab_i;
        ipi_o = |(live & IPI_M);
        msi_o = |(live & MSI_M);
    end

    assert_rsvd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_i & ~RSV_M) == '0) |-> (!ipi_o && !msi_o));

endmodule

// File: rtl/dbu_doorbell_unit.sv
module dbu_doorbell_unit
    import dbu_pkg::*;
#(
    parameter int NUM_CPU = 4,
    localparam int CIW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_valid,
    input  logic [DB_W-1:0]    trig_data,
    input  logic               reg_we,
    input  logic [3:0]         reg_addr,
    input  logic [CIW-1:0]     reg_cpu,
    input  logic [DB_W-1:0]    reg_wdata,
    output logic [DB_W-1:0]    reg_rdata,
    output logic [NUM_CPU-1:0] ipi_irq,
    output logic [NUM_CPU-1:0] msi_irq
);

    logic [NUM_CPU-1:0][DB_W-1:0] set_v;
    logic [NUM_CPU-1:0][DB_W-1:0] pend_v;
    logic [NUM_CPU-1:0][DB_W-1:0] enab_v;
    logic                         cpu_ok;

    assign cpu_ok = (int'(reg_cpu) < NUM_CPU);

    dbu_trig_decode #(.NUM_CPU(NUM_CPU)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_valid (trig_valid),
        .trig_data  (trig_data),
        .set_o      (set_v)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
        logic hit;
        assign hit = reg_we && cpu_ok && (int'(reg_cpu) == c);

        dbu_cpu_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (set_v[c]),
            .pend_we_i (hit && reg_addr == OFS_PEND),
            .enab_we_i (hit && reg_addr == OFS_ENAB),
            .wdata_i   (reg_wdata),
            .pend_o    (pend_v[c]),
            .enab_o    (enab_v[c])
        );

        dbu_group_sum u_sum (
            .clk    (clk),
            .rst_n  (rst_n),
            .pend_i (pend_v[c]),
            .enab_i (enab_v[c]),
            .ipi_o  (ipi_irq[c]),
            .msi_o  (msi_irq[c])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (cpu_ok) begin
            if (reg_addr == OFS_PEND)      reg_rdata = pend_v[reg_cpu];
            else if (reg_addr == OFS_ENAB) reg_rdata = enab_v[reg_cpu];
        end
    end

    assert_msi_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && trig_data[15:0] == 16'h0F10) |=> (pend_v[0][16] && pend_v[NUM_CPU-1][16]));

endmodule

// File: tb/dbu_doorbell_unit_bench.sv
module dbu_doorbell_unit_bench;

    localparam int CLK_P = 10;
    localparam int NCPU  = 4;
    localparam logic [31:0] IPI_M = 32'h0000_00FF;
    localparam logic [31:0] MSI_M = 32'hFFFF_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        trig_valid = 1'b0;
    logic [31:0] trig_data = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [1:0]  reg_cpu = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  ipi_irq, msi_irq;

    logic [31:0] m_pend [NCPU];
    logic [31:0] m_enab [NCPU];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    dbu_doorbell_unit #(.NUM_CPU(NCPU)) u_dbu_doorbell_unit (
        .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_data(trig_data),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_cpu(reg_cpu), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ipi_irq(ipi_irq), .msi_irq(msi_irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, input int c, output logic [31:0] v);
        reg_addr = a; reg_cpu = 2'(c); #1; v = reg_rdata;
    endtask

    task automatic check_all(input string req);
        logic [31:0] v;
        for (int c = 0; c < NCPU; c++) begin
            rd(4'h8, c, v); chk({req, " pend R10"}, v, m_pend[c]);
            rd(4'hC, c, v); chk({req, " enab R5"}, v, m_enab[c]);
            chk({req, " ipi R6"}, 32'(ipi_irq[c]), 32'(|(m_pend[c] & m_enab[c] & IPI_M)));
            chk({req, " msi R7"}, 32'(msi_irq[c]), 32'(|(m_pend[c] & m_enab[c] & MSI_M)));
        end
    endtask

    task automatic model_trig(input logic [31:0] d);
        for (int c = 0; c < NCPU; c++)
            if (d[8+c]) m_pend[c][d[4:0]] = 1'b1;
    endtask

    // one cycle, optionally both a trigger and a register write
    task automatic cycle(input bit tv, input logic [31:0] td,
                         input bit we, input logic [3:0] a, input int c, input logic [31:0] wd);
        @(negedge clk);
        trig_valid = tv; trig_data = td;
        reg_we = we; reg_addr = a; reg_cpu = 2'(c); reg_wdata = wd;
        if (we && a == 4'h8) m_pend[c] = m_pend[c] & wd;
        if (we && a == 4'hC) m_enab[c] = wd;
        if (tv) model_trig(td);
        @(negedge clk);
        trig_valid = 1'b0; reg_we = 1'b0;
    endtask

    task automatic clear_all();
        for (int c = 0; c < NCPU; c++) cycle(0, '0, 1, 4'h8, c, 32'h0);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int c = 0; c < NCPU; c++) begin m_pend[c] = '0; m_enab[c] = '0; end
        #1 rst_n = 1'b0;
        #(CLK_P*3) rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");
        chk("R1 ipi", 32'(ipi_irq), 0);
        chk("R1 msi", 32'(msi_irq), 0);

        // R5 enable load and readback
        for (int c = 0; c < NCPU; c++) cycle(0, '0, 1, 4'hC, c, 32'hA5C3_0F00 ^ (32'h1111_1111 << c));
        check_all("R5 enab pattern");
        for (int c = 0; c < NCPU; c++) cycle(0, '0, 1, 4'hC, c, 32'hFFFF_FFFF);

        // R2 sweep: every doorbell number against every CPU map, all enabled
        for (int b = 0; b < 32; b++) begin
            for (int m = 0; m < 16; m++) begin
                cycle(1, (32'(m) << 8) | 32'(b), 0, 4'h0, 0, '0);
                check_all(b >= 8 && b < 16 ? "R2 R8 rsvd trig" : "R2 trig sweep");
                clear_all();
            end
        end

        // R3 message-signalled values
        for (int n = 0; n < 16; n++) begin
            cycle(1, 32'hF00 | 32'(n + 16), 0, 4'h0, 0, '0);
            for (int c = 0; c < NCPU; c++) begin
                rd(4'h8, c, v); chk("R3 msi lands", v, 32'h1 << (16 + n));
            end
            chk("R3 msi_irq", 32'(msi_irq), 32'hF);
            chk("R3 ipi quiet", 32'(ipi_irq), 0);
            clear_all();
        end

        // R4 partial clear
        for (int b = 0; b < 32; b += 3) cycle(1, 32'h0F00 | 32'(b), 0, 4'h0, 0, '0);
        cycle(0, '0, 1, 4'h8, 1, 32'hF0F0_F0F0);
        cycle(0, '0, 1, 4'h8, 2, 32'hFFFF_FFFF);
        check_all("R4 partial clear");
        clear_all();
        check_all("R4 clear all");

        // R6/R7 gating by the enable register
        cycle(1, 32'h0F03, 0, 4'h0, 0, '0);
        cycle(1, 32'h0F14, 0, 4'h0, 0, '0);
        for (int c = 0; c < NCPU; c++) cycle(0, '0, 1, 4'hC, c, 32'h0);
        check_all("R6 R7 all disabled");
        cycle(0, '0, 1, 4'hC, 0, 32'h0000_0008);
        cycle(0, '0, 1, 4'hC, 1, 32'h0010_0000);
        cycle(0, '0, 1, 4'hC, 2, 32'h0000_0004);
        check_all("R6 R7 selective enable");
        clear_all();

        // R8 reserved bits enabled but pending: no output
        for (int c = 0; c < NCPU; c++) cycle(0, '0, 1, 4'hC, c, 32'hFFFF_FFFF);
        for (int b = 8; b < 16; b++) cycle(1, 32'h0F00 | 32'(b), 0, 4'h0, 0, '0);
        check_all("R8 reserved");
        chk("R8 ipi", 32'(ipi_irq), 0);
        chk("R8 msi", 32'(msi_irq), 0);
        clear_all();

        // R9 trigger and clear in the same cycle
        cycle(1, 32'h0103, 0, 4'h0, 0, '0);
        cycle(1, 32'h0103, 1, 4'h8, 0, 32'h0);
        rd(4'h8, 0, v); chk("R9 pending bit kept", v, 32'h0000_0008);
        cycle(1, 32'h0115, 1, 4'h8, 0, 32'h0);
        rd(4'h8, 0, v); chk("R9 idle bit set", v, 32'h0020_0000);
        cycle(1, 32'h0206, 1, 4'h8, 0, 32'h0);
        check_all("R9 other cpu");
        clear_all();

        // R10 other offsets read zero
        cycle(1, 32'h0F1F, 0, 4'h0, 0, '0);
        for (int a = 0; a < 16; a++) begin
            if (a != 8 && a != 12) begin
                rd(4'(a), 3, v); chk("R10 unused offset", v, 32'h0);
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule